// File: doc/BRIEF.md
# Audio Modulation Tick Generator

This block produces the slow timing strobes that pace the modulation units of a sound generator. A clock divider turns the system clock into a 512 Hz base event. Each base event steps a 3-bit phase counter through a cycle of eight steps. The phase in effect when an event arrives is decoded into three single-cycle strobes: one for the length counters, one for the frequency sweep unit and one for the volume envelopes.

The schedule is not a set of plain power-of-two dividers. The length strobe fires on every other step, and the sweep strobe fires on two of those same steps. The envelope strobe fires on the one odd step that ends the cycle. Downstream channel logic uses each strobe as a clock enable.

Top module: `fs_tick_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the phase and the divider count return to 0 and all three strobes are low in the following cycle.
- R2: With `enable` high, a base event occurs on every DIV_RATIO-th enabled cycle, counted from reset. Each base event advances `phase_o` by one.
- R3: `len_stb_o` goes high in the cycle after a base event that occurred while the phase was 0, 2, 4 or 6.
- R4: `sweep_stb_o` goes high in the cycle after a base event that occurred while the phase was 2 or 6.
- R5: `env_stb_o` goes high in the cycle after a base event that occurred while the phase was 7.
- R6: Every strobe is high for exactly one system clock. All strobes stay low in cycles that do not follow a base event.
- R7: While `enable` is low, the divider count and the phase hold their values and no strobe is issued. Counting resumes from the held count once `enable` returns high.
- R8: After phase 7, the next base event returns the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Lets the divider and the phase counter advance |
| len_stb_o | output | 1 | Length counter strobe, 256 Hz |
| sweep_stb_o | output | 1 | Frequency sweep strobe, 128 Hz |
| env_stb_o | output | 1 | Volume envelope strobe, 64 Hz |
| phase_o | output | 3 | Current step of the 8-step cycle |

## Verification
The bench builds the block with DIV_RATIO set to 5 in place of the system-rate default. A full 8-step cycle then takes 40 clocks, so several wraps of the phase fit into a short run. At that ratio, pulses of `enable` and a reset can also land on every position of the divider count. The odd ratio also means that an enable gap is visible as a shift of the whole strobe pattern.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef logic [2:0] phase_t;

    typedef struct packed {
        logic len;
        logic sweep;
        logic env;
    } strobe_t;

    localparam strobe_t STROBE_NONE = '{len: 1'b0, sweep: 1'b0, env: 1'b0};

    // Map the step in effect at a base event to the strobes it releases.
    function automatic strobe_t decode_phase(input phase_t p);
        strobe_t s;
        s.len   = ~p[0];
        s.sweep = p[1] & ~p[0];
        s.env   = &p;
        return s;
    endfunction

endpackage

// File: rtl/fs_divider.sv
module fs_divider #(
    parameter int DIV_RATIO = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic tick
);
    localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] count_q;

    assign tick = enable && (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (enable) begin
            if (count_q == LAST) count_q <= '0;
            else                 count_q <= count_q + 1'b1;
        end
    end

    p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(enable)) |-> (count_q == $past(count_q)))
        else $error("divider moved while disabled");

    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        count_q <= LAST)
        else $error("divider count out of range");
endmodule

// File: rtl/fs_phase.sv
module fs_phase
    import fs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    output phase_t phase
);
    phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (tick) phase_q <= phase_q + 3'd1;
    end

    assign phase = phase_q;

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick)) |-> (phase_q == phase_t'($past(phase_q) + 3'd1)))
        else $error("phase did not step on base event");

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && $past(phase_q) == 3'd7) |-> (phase_q == 3'd0))
        else $error("phase did not wrap");
endmodule

// File: rtl/fs_strobe_reg.sv
module fs_strobe_reg
    import fs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  phase_t  phase,
    output strobe_t strobes
);
    strobe_t strobes_q;

    always_ff @(posedge clk) begin
        if (rst)       strobes_q <= STROBE_NONE;
        else if (tick) strobes_q <= decode_phase(phase);
        else           strobes_q <= STROBE_NONE;
    end

    assign strobes = strobes_q;

    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> (strobes_q == STROBE_NONE))
        else $error("strobe without base event");
endmodule

// File: rtl/fs_tick_gen.sv
module fs_tick_gen
    import fs_pkg::*;
#(
    parameter int DIV_RATIO = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    output logic       len_stb_o,
    output logic       sweep_stb_o,
    output logic       env_stb_o,
    output logic [2:0] phase_o
);
    logic    base_tick;
    phase_t  phase;
    strobe_t strobes;

    fs_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk(clk), .rst(rst), .enable(enable), .tick(base_tick)
    );

    fs_phase u_phase (
        .clk(clk), .rst(rst), .tick(base_tick), .phase(phase)
    );

    fs_strobe_reg u_strobe (
        .clk(clk), .rst(rst), .tick(base_tick), .phase(phase), .strobes(strobes)
    );

    assign phase_o     = phase;
    assign len_stb_o   = strobes.len;
    assign sweep_stb_o = strobes.sweep;
    assign env_stb_o   = strobes.env;

    // Strobes show up alongside the already advanced phase.
    p_len_phase_r3: assert property (@(posedge clk) disable iff (rst)
        len_stb_o |-> phase_o[0])
        else $error("length strobe on wrong step");

    p_sweep_phase_r4: assert property (@(posedge clk) disable iff (rst)
        sweep_stb_o |-> (phase_o == 3'd3 || phase_o == 3'd7))
        else $error("sweep strobe on wrong step");

    p_env_phase_r5: assert property (@(posedge clk) disable iff (rst)
        env_stb_o |-> (phase_o == 3'd0))
        else $error("envelope strobe on wrong step");

    p_single_r6: assert property (@(posedge clk) disable iff (rst)
        (len_stb_o || env_stb_o) |=> !(len_stb_o || env_stb_o))
        else $error("strobe wider than one clock");

    p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(enable)) |-> $stable(phase_o))
        else $error("phase moved while disabled");

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (phase_o == 3'd0 && !len_stb_o && !sweep_stb_o && !env_stb_o))
        else $error("reset state wrong");
endmodule

// File: tb/test_fs_tick_gen.sv
module test_fs_tick_gen;
    localparam int DIV = 5;

    typedef struct {
        logic [2:0] ph;
        logic       len;
        logic       sw;
        logic       env;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic len_stb_o, sweep_stb_o, env_stb_o;
    logic [2:0] phase_o;

    exp_t q[$];
    int   vectors = 0;
    int   errors = 0;
    bit   done = 1'b0;

    int       m_cnt = 0;
    logic [2:0] m_ph = '0;

    always #10 clk = ~clk;

    fs_tick_gen #(.DIV_RATIO(DIV)) i_fs_tick_gen (
        .clk(clk), .rst(rst), .enable(enable),
        .len_stb_o(len_stb_o), .sweep_stb_o(sweep_stb_o),
        .env_stb_o(env_stb_o), .phase_o(phase_o)
    );

    // Driver: apply inputs for one cycle and push what the outputs must be after the edge.
    task automatic step(input logic r, input logic e);
        exp_t x;
        rst = r;
        enable = e;
        x.len = 1'b0; x.sw = 1'b0; x.env = 1'b0;
        if (r) begin
            m_cnt = 0; m_ph = '0; x.tag = "R1";
        end else if (!e) begin
            x.tag = "R7";
        end else if (m_cnt == DIV - 1) begin
            x.len = (m_ph[0] == 1'b0);          // R3
            x.sw  = (m_ph == 3'd2 || m_ph == 3'd6); // R4
            x.env = (m_ph == 3'd7);              // R5
            x.tag = (m_ph == 3'd7) ? "R8/R5" : "R2/R3/R4";
            m_cnt = 0;
            m_ph  = m_ph + 3'd1;
        end else begin
            m_cnt = m_cnt + 1;
            x.tag = "R6";
        end
        x.ph = m_ph;
        q.push_back(x);
        @(negedge clk);
        #1;
    endtask

    // Monitor: compare what the design shows against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                vectors++;
                if (phase_o !== x.ph) begin
                    errors++;
                    $display("FAIL %s phase: got %0d expected %0d", x.tag, phase_o, x.ph);
                end
                if (len_stb_o !== x.len) begin
                    errors++;
                    $display("FAIL %s/R3 len: got %b expected %b", x.tag, len_stb_o, x.len);
                end
                if (sweep_stb_o !== x.sw) begin
                    errors++;
                    $display("FAIL %s/R4 sweep: got %b expected %b", x.tag, sweep_stb_o, x.sw);
                end
                if (env_stb_o !== x.env) begin
                    errors++;
                    $display("FAIL %s/R5 env: got %b expected %b", x.tag, env_stb_o, x.env);
                end
            end
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        // R2/R3/R4/R5/R8: three full cycles of eight steps
        for (int i = 0; i < 3 * 8 * DIV; i++) step(1'b0, 1'b1);
        // R7: gaps of enable at varied divider positions
        for (int i = 0; i < 60; i++) step(1'b0, (i % 7) != 3 && (i % 11) != 5);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 2 * DIV + 2; i++) step(1'b0, 1'b1);
        // R1: reset in the middle of a run, then restart
        step(1'b1, 1'b1);
        for (int i = 0; i < 8 * DIV + 3; i++) step(1'b0, 1'b1);
        // alternating enable stretches the schedule
        for (int i = 0; i < 8 * DIV * 2; i++) step(1'b0, i[0]);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule